// File: doc/BRIEF.md
# Multi-Port In-Order Commit Buffer

The commit buffer is a circular store of speculative results that are released to the architectural register file in program order. At issue time, up to four operations claim consecutive slots at the tail. Each claim records the destination register index, and the buffer returns the slot number as a tag. Execution results and load returns then arrive in any order over four independent write ports. Each write stores the data and marks the slot complete. Consumers can read not-yet-committed values and their completion state through read ports, using the tag.

Every cycle the buffer retires the oldest slots that are complete. It retires at most four, and it stops at the first slot that is not complete, even if younger slots are done. Retired values go to a registered register-file write interface one cycle later, and only then are they architecturally visible. A flush discards every live slot, clears all completion flags and moves the tail back to the head.

An occupancy state machine drives the empty and full indications. It has three states: `OCC_EMPTY`, `OCC_OPEN` and `OCC_FULL`. The transitions are:
- fill: `OCC_EMPTY` to `OCC_OPEN`, on allocation.
- fill-to-capacity: `OCC_OPEN` to `OCC_FULL`, when the live count reaches the depth. `OCC_EMPTY` can also go straight to `OCC_FULL` when the depth is reached in one step.
- release: `OCC_FULL` to `OCC_OPEN`, on retirement.
- drain: `OCC_OPEN` or `OCC_FULL` to `OCC_EMPTY`, when the count returns to zero.
- flush: any state to `OCC_EMPTY`.

Top module: `commit_buffer`

## Requirements
- R1: After reset the buffer is empty: `buf_empty`=1, `buf_full`=0 and `rf_we`=0.
- R2: A request of `alloc_cnt` slots (0 to 4) is accepted, with `alloc_ok`=1, exactly when `alloc_cnt` is no larger than the number of free slots and `flush` is low. When the request is refused, `alloc_ok`=0 and no slot is claimed.
- R3: The buffer holds 32 slots. `alloc_tag` is the slot given to the first claimed operation, and the following operations get consecutive tags modulo 32. `buf_full`=1 exactly when 32 slots are live, and `buf_empty`=1 exactly when none are live.
- R4: Any of the four write ports can complete any live slot in any order, and all ports take effect in the same cycle. Ports 0 and 1 carry execution results and ports 2 and 3 carry load data. At most one port may target a given slot in a cycle.
- R5: Each cycle, up to four of the oldest live slots retire. Retirement stops at the first slot that is not complete.
- R6: A slot retired at clock edge t appears on the register-file interface after edge t and before edge t+1. Lane 0 carries the oldest retired slot, and lanes are filled from lane 0 upward with no gaps. `rf_addr` and `rf_data` of a lane carry that slot's destination index and data.
- R7: A flush discards all live slots, clears their completion flags and retires nothing in that cycle. After the flush the buffer is empty and the next claimed tag equals the head slot.
- R8: Read port r returns `rd_done[r]` and `rd_data` for the slot addressed by its tag, combinationally. A slot that was written shows `rd_done`=1 and its data from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all live slots |
| alloc_cnt | input | 3 | Number of slots requested this cycle (0 to 4) |
| alloc_dst | input | 24 | Destination register index per requested slot, 6 bits each, operation 0 in the low bits |
| alloc_ok | output | 1 | Request accepted |
| alloc_tag | output | 5 | Tag of the first claimed slot |
| wr_vld | input | 4 | Write valid per port (0 and 1 execution, 2 and 3 load) |
| wr_tag | input | 20 | Slot tag per write port, 5 bits each |
| wr_data | input | 128 | Result data per write port, 32 bits each |
| rd_tag | input | 10 | Slot tag per read port, 5 bits each |
| rd_done | output | 2 | Completion flag of the addressed slot per read port |
| rd_data | output | 64 | Data of the addressed slot per read port |
| rf_we | output | 4 | Register-file write enable per lane |
| rf_addr | output | 24 | Register index per lane, 6 bits each |
| rf_data | output | 128 | Write data per lane, 32 bits each |
| buf_empty | output | 1 | No live slot |
| buf_full | output | 1 | All 32 slots live |

## Verification
The bench first makes younger slots complete while the head is still pending. A design that skips the pending head would write younger registers early, out of program order. It then completes six slots at once, so retirement has to split into a group of four and a group of two. A design with a wrong width limit would show the wrong lane pattern, or would lose or duplicate entries in the scoreboard.

The bench fills the buffer to 30 slots and requests three, then two, then one more. A design that compares free slots off by one would either overrun the ring or refuse a request that fits. A flush issued while some slots are already complete must leave no register-file write and no stale completion flag behind. The flush must also place the next tag at the old head.

// File: rtl/cb_pkg.sv
package cb_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_OPEN  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/cb_entry_store.sv
module cb_entry_store #(
    parameter int DEPTH   = 32,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 6,
    parameter int N_WR    = 4,
    parameter int N_ALLOC = 4,
    parameter int N_RD    = 2,
    parameter int N_CMT   = 4,
    parameter int TAG_W   = 5,
    parameter int AC_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      alloc_fire,
    input  logic [TAG_W-1:0]          alloc_base,
    input  logic [AC_W-1:0]           alloc_cnt,
    input  logic [N_ALLOC*REG_W-1:0]  alloc_dst,
    input  logic [N_WR-1:0]           wr_vld,
    input  logic [N_WR*TAG_W-1:0]     wr_tag,
    input  logic [N_WR*DATA_W-1:0]    wr_data,
    input  logic [N_RD*TAG_W-1:0]     rd_tag,
    output logic [N_RD-1:0]           rd_done,
    output logic [N_RD*DATA_W-1:0]    rd_data,
    input  logic [TAG_W-1:0]          head,
    output logic [N_CMT-1:0]          cmt_done,
    output logic [N_CMT*REG_W-1:0]    cmt_dst,
    output logic [N_CMT*DATA_W-1:0]   cmt_data
);

    logic [DEPTH-1:0]  done_q;
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [REG_W-1:0]  dst_q  [DEPTH];

    // completion flags: set by writes, cleared by allocation and flush
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (flush) begin
            done_q <= '0;
        end else begin
            for (int w = 0; w < N_WR; w++) begin
                if (wr_vld[w]) begin
                    done_q[wr_tag[w*TAG_W +: TAG_W]] <= 1'b1;
                end
            end
            if (alloc_fire) begin
                for (int a = 0; a < N_ALLOC; a++) begin
                    if (AC_W'(a) < alloc_cnt) begin
                        done_q[alloc_base + TAG_W'(a)] <= 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < N_WR; w++) begin
            if (wr_vld[w] && !flush) begin
                data_q[wr_tag[w*TAG_W +: TAG_W]] <= wr_data[w*DATA_W +: DATA_W];
            end
        end
        if (alloc_fire) begin
            for (int a = 0; a < N_ALLOC; a++) begin
                if (AC_W'(a) < alloc_cnt) begin
                    dst_q[alloc_base + TAG_W'(a)] <= alloc_dst[a*REG_W +: REG_W];
                end
            end
        end
    end

    always_comb begin
        for (int r = 0; r < N_RD; r++) begin
            rd_done[r]                  = done_q[rd_tag[r*TAG_W +: TAG_W]];
            rd_data[r*DATA_W +: DATA_W] = data_q[rd_tag[r*TAG_W +: TAG_W]];
        end
    end

    always_comb begin
        for (int i = 0; i < N_CMT; i++) begin
            cmt_done[i]                  = done_q[head + TAG_W'(i)];
            cmt_dst[i*REG_W +: REG_W]    = dst_q[head + TAG_W'(i)];
            cmt_data[i*DATA_W +: DATA_W] = data_q[head + TAG_W'(i)];
        end
    end

    // R4: at most one write port may name a given slot per cycle
    always_ff @(posedge clk) begin
        if (rst_n && !flush) begin
            for (int w1 = 0; w1 < N_WR; w1++) begin
                for (int w2 = w1 + 1; w2 < N_WR; w2++) begin
                    a_r4_one_writer: assert (!(wr_vld[w1] && wr_vld[w2] &&
                        wr_tag[w1*TAG_W +: TAG_W] == wr_tag[w2*TAG_W +: TAG_W]))
                        else $error("two write ports hit one slot");
                end
            end
        end
    end

endmodule

// File: rtl/cb_retire_scan.sv
module cb_retire_scan #(
    parameter int N_CMT = 4,
    parameter int CNT_W = 6,
    parameter int CC_W  = 3
) (
    input  logic [N_CMT-1:0] cmt_done,
    input  logic [CNT_W-1:0] count,
    output logic [N_CMT-1:0] cmt_mask,
    output logic [CC_W-1:0]  cmt_n
);

    logic run;

    // walk from the head; the first incomplete or empty slot ends the run
    always_comb begin
        run   = 1'b1;
        cmt_n = '0;
        for (int i = 0; i < N_CMT; i++) begin
            cmt_mask[i] = run && cmt_done[i] && (CNT_W'(i) < count);
            run         = cmt_mask[i];
            cmt_n       = cmt_n + CC_W'(cmt_mask[i]);
        end
    end

endmodule

// File: rtl/cb_ring_ctrl.sv
module cb_ring_ctrl
    import cb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TAG_W = 5,
    parameter int CNT_W = 6,
    parameter int AC_W  = 3,
    parameter int CC_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [AC_W-1:0]  alloc_cnt,
    input  logic [CC_W-1:0]  cmt_n,
    output logic             alloc_ok,
    output logic             alloc_fire,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             buf_empty,
    output logic             buf_full
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    occ_state_e       occ_q, occ_d;
    logic [CNT_W-1:0] free, add, count_n;

    always_comb begin
        free       = CAP - count;
        alloc_ok   = !flush && (CNT_W'(alloc_cnt) <= free);
        alloc_fire = alloc_ok && (alloc_cnt != '0);
        add        = alloc_fire ? CNT_W'(alloc_cnt) : '0;
        count_n    = flush ? '0 : count + add - CNT_W'(cmt_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            head  <= head + TAG_W'(cmt_n);
            tail  <= tail + TAG_W'(add);
            count <= count_n;
        end
    end

    // occupancy state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_d;
    end

    // transitions: fill, fill-to-capacity, release, drain, flush
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (count_n == CAP)      occ_d = OCC_FULL;
                else if (count_n != '0)  occ_d = OCC_OPEN;
            end
            OCC_OPEN: begin
                if (count_n == '0)       occ_d = OCC_EMPTY;
                else if (count_n == CAP) occ_d = OCC_FULL;
            end
            OCC_FULL: begin
                if (count_n == '0)       occ_d = OCC_EMPTY;
                else if (count_n != CAP) occ_d = OCC_OPEN;
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    always_comb begin
        buf_empty = 1'b0;
        buf_full  = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: buf_empty = 1'b1;
            OCC_OPEN:  ;
            OCC_FULL:  buf_full  = 1'b1;
            default:   buf_empty = 1'b1;
        endcase
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP) else $error("live count above depth");

    a_r3_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full == (count == CAP)) && (buf_empty == (count == '0)))
        else $error("occupancy state disagrees with count");

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (buf_empty && tail == head)) else $error("flush left live slots");

    a_r2_refused_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_fire && !flush) |=> tail == $past(tail))
        else $error("tail moved without allocation");

endmodule

// File: rtl/commit_buffer.sv
module commit_buffer #(
    parameter int DEPTH   = 32,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 6,
    parameter int N_WR    = 4,
    parameter int N_CMT   = 4,
    parameter int N_ALLOC = 4,
    parameter int N_RD    = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   flush,
    input  logic [$clog2(N_ALLOC+1)-1:0]           alloc_cnt,
    input  logic [N_ALLOC*REG_W-1:0]               alloc_dst,
    output logic                                   alloc_ok,
    output logic [$clog2(DEPTH)-1:0]               alloc_tag,
    input  logic [N_WR-1:0]                        wr_vld,
    input  logic [N_WR*$clog2(DEPTH)-1:0]          wr_tag,
    input  logic [N_WR*DATA_W-1:0]                 wr_data,
    input  logic [N_RD*$clog2(DEPTH)-1:0]          rd_tag,
    output logic [N_RD-1:0]                        rd_done,
    output logic [N_RD*DATA_W-1:0]                 rd_data,
    output logic [N_CMT-1:0]                       rf_we,
    output logic [N_CMT*REG_W-1:0]                 rf_addr,
    output logic [N_CMT*DATA_W-1:0]                rf_data,
    output logic                                   buf_empty,
    output logic                                   buf_full
);

    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AC_W  = $clog2(N_ALLOC + 1);
    localparam int CC_W  = $clog2(N_CMT + 1);

    logic                    alloc_fire;
    logic [TAG_W-1:0]        head, tail;
    logic [CNT_W-1:0]        count;
    logic [N_CMT-1:0]        cmt_done, cmt_mask;
    logic [CC_W-1:0]         cmt_n, cmt_n_eff;
    logic [N_CMT*REG_W-1:0]  cmt_dst;
    logic [N_CMT*DATA_W-1:0] cmt_data;

    assign alloc_tag = tail;
    assign cmt_n_eff = flush ? '0 : cmt_n;

    cb_ring_ctrl #(
        .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .AC_W(AC_W), .CC_W(CC_W)
    ) i_ring (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_cnt(alloc_cnt), .cmt_n(cmt_n_eff),
        .alloc_ok(alloc_ok), .alloc_fire(alloc_fire),
        .head(head), .tail(tail), .count(count),
        .buf_empty(buf_empty), .buf_full(buf_full)
    );

    cb_entry_store #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .N_WR(N_WR),
        .N_ALLOC(N_ALLOC), .N_RD(N_RD), .N_CMT(N_CMT), .TAG_W(TAG_W), .AC_W(AC_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_fire(alloc_fire), .alloc_base(tail),
        .alloc_cnt(alloc_cnt), .alloc_dst(alloc_dst),
        .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_data(wr_data),
        .rd_tag(rd_tag), .rd_done(rd_done), .rd_data(rd_data),
        .head(head), .cmt_done(cmt_done), .cmt_dst(cmt_dst), .cmt_data(cmt_data)
    );

    cb_retire_scan #(
        .N_CMT(N_CMT), .CNT_W(CNT_W), .CC_W(CC_W)
    ) i_scan (
        .cmt_done(cmt_done), .count(count),
        .cmt_mask(cmt_mask), .cmt_n(cmt_n)
    );

    // register-file write stage, one cycle behind retirement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_we <= '0;
        else        rf_we <= flush ? '0 : cmt_mask;
    end

    always_ff @(posedge clk) begin
        rf_addr <= cmt_dst;
        rf_data <= cmt_data;
    end

    a_r5_commit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(cmt_n) <= count) else $error("retiring more than live");

    a_r6_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((rf_we + 1'b1) & rf_we) == '0) else $error("register-file lanes not packed");

    a_r6_rf_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we != '0) |-> $past(cmt_n != '0 && !flush))
        else $error("register-file write without a retirement");

    // R4: every write targets a live slot
    for (genvar w = 0; w < N_WR; w++) begin : g_wlive
        a_r4_write_live: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld[w] && !flush) |->
            (CNT_W'(TAG_W'(wr_tag[w*TAG_W +: TAG_W] - head)) < count))
            else $error("write to a slot that is not live");
    end

endmodule

// File: tb/test_commit_buffer.sv
module test_commit_buffer;

    localparam int DEPTH = 32, DATA_W = 32, REG_W = 6, N_WR = 4;
    localparam int N_CMT = 4, N_ALLOC = 4, N_RD = 2, TAG_W = 5, AC_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic [AC_W-1:0]           alloc_cnt = '0;
    logic [N_ALLOC*REG_W-1:0]  alloc_dst = '0;
    logic [N_WR-1:0]           wr_vld = '0;
    logic [N_WR*TAG_W-1:0]     wr_tag = '0;
    logic [N_WR*DATA_W-1:0]    wr_data = '0;
    logic [N_RD*TAG_W-1:0]     rd_tag = '0;
    logic                      alloc_ok, buf_empty, buf_full;
    logic [TAG_W-1:0]          alloc_tag;
    logic [N_RD-1:0]           rd_done;
    logic [N_RD*DATA_W-1:0]    rd_data;
    logic [N_CMT-1:0]          rf_we;
    logic [N_CMT*REG_W-1:0]    rf_addr;
    logic [N_CMT*DATA_W-1:0]   rf_data;

    always #5 clk = ~clk;

    commit_buffer i_commit_buffer (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_cnt(alloc_cnt), .alloc_dst(alloc_dst), .alloc_ok(alloc_ok),
        .alloc_tag(alloc_tag), .wr_vld(wr_vld), .wr_tag(wr_tag), .wr_data(wr_data),
        .rd_tag(rd_tag), .rd_done(rd_done), .rd_data(rd_data),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .buf_empty(buf_empty), .buf_full(buf_full)
    );

    typedef struct {
        logic [REG_W-1:0]  dst;
        logic [DATA_W-1:0] val;
    } exp_t;

    exp_t              exp_q[$];
    int                pend[$];
    logic [DATA_W-1:0] val_of [DEPTH];
    int head_m = 0, tail_m = 0, alloc_total = 0, retired_total = 0;
    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        #2;
        alloc_cnt = '0;
        wr_vld    = '0;
        flush     = 1'b0;
    endtask

    task automatic do_alloc(input int n, input bit expect_ok);
        alloc_cnt = AC_W'(n);
        for (int a = 0; a < N_ALLOC; a++) alloc_dst[a*REG_W +: REG_W] = REG_W'($urandom_range(0, 63));
        #1;
        chk(alloc_ok == expect_ok, "R2 alloc_ok", alloc_ok, expect_ok);
        if (expect_ok && n > 0) begin
            chk(alloc_tag == TAG_W'(tail_m), "R3 alloc_tag", alloc_tag, tail_m);
            for (int a = 0; a < n; a++) begin
                int t;
                t = (tail_m + a) % DEPTH;
                val_of[t] = $urandom;
                exp_q.push_back('{alloc_dst[a*REG_W +: REG_W], val_of[t]});
                pend.push_back(t);
            end
            tail_m = (tail_m + n) % DEPTH;
            alloc_total += n;
        end
    endtask

    task automatic try_alloc(input int n);
        do_alloc(n, n <= DEPTH - (alloc_total - retired_total));
    endtask

    task automatic do_write(input int p, input int t);
        wr_vld[p] = 1'b1;
        wr_tag[p*TAG_W +: TAG_W]    = TAG_W'(t);
        wr_data[p*DATA_W +: DATA_W] = val_of[t];
        for (int j = 0; j < pend.size(); j++) begin
            if (pend[j] == t) begin
                pend.delete(j);
                break;
            end
        end
    endtask

    task automatic drain();
        while (pend.size() > 0) begin
            for (int p = 0; p < N_WR && pend.size() > 0; p++) do_write(p, pend[0]);
            cycle();
        end
        repeat (12) cycle();
        chk(exp_q.size() == 0, "R5 all entries retired", exp_q.size(), 0);
        chk(buf_empty == 1'b1, "R3 empty after drain", buf_empty, 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // scoreboard monitor: register-file writes must follow program order (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we != '0)
                chk(((rf_we + 1'b1) & rf_we) == '0, "R6 lanes packed from lane 0", rf_we, 0);
            for (int i = 0; i < N_CMT; i++) begin
                if (rf_we[i]) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected register-file write", i, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(rf_addr[i*REG_W +: REG_W] == e.dst, "R6 rf_addr in program order",
                            rf_addr[i*REG_W +: REG_W], e.dst);
                        chk(rf_data[i*DATA_W +: DATA_W] == e.val, "R6 rf_data in program order",
                            rf_data[i*DATA_W +: DATA_W], e.val);
                        head_m = (head_m + 1) % DEPTH;
                        retired_total++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        chk(buf_empty == 1'b1, "R1 empty at reset", buf_empty, 1);
        chk(buf_full == 1'b0, "R1 not full at reset", buf_full, 0);
        chk(rf_we == '0, "R1 no rf write at reset", rf_we, 0);
        rst_n = 1'b1;
        cycle();

        // R5: head pending blocks younger completed slots
        try_alloc(3);
        cycle();
        h = head_m;
        do_write(0, (h + 1) % DEPTH);
        do_write(2, (h + 2) % DEPTH);
        cycle();
        cycle();
        chk(rf_we == 4'b0000, "R5 stall on incomplete head", rf_we, 0);
        rd_tag = {TAG_W'(h), TAG_W'((h + 1) % DEPTH)};
        #1;
        chk(rd_done == 2'b01, "R8 rd_done written vs pending", rd_done, 2'b01);
        chk(rd_data[DATA_W-1:0] == val_of[(h + 1) % DEPTH], "R8 rd_data", rd_data[DATA_W-1:0],
            val_of[(h + 1) % DEPTH]);
        do_write(3, h);
        cycle();
        cycle();
        chk(rf_we == 4'b0111, "R5 three retire together", rf_we, 4'b0111);

        // R4 / R5: six done slots retire as four then two
        try_alloc(4);
        cycle();
        try_alloc(2);
        cycle();
        h = head_m;
        for (int p = 0; p < N_WR; p++) do_write(p, (h + 1 + p) % DEPTH);
        cycle();
        do_write(0, h);
        do_write(3, (h + 5) % DEPTH);
        cycle();
        cycle();
        chk(rf_we == 4'b1111, "R5 four per cycle limit", rf_we, 4'b1111);
        cycle();
        chk(rf_we == 4'b0011, "R5 remaining two", rf_we, 4'b0011);
        cycle();
        chk(rf_we == 4'b0000, "R4 nothing left", rf_we, 0);

        // R2 / R3: fill to capacity
        for (int k = 0; k < 7; k++) begin
            try_alloc(4);
            cycle();
        end
        try_alloc(2);
        cycle();
        do_alloc(3, 1'b0);
        chk(buf_full == 1'b0, "R3 not full at 30", buf_full, 0);
        do_alloc(2, 1'b1);
        cycle();
        chk(buf_full == 1'b1, "R3 full at 32", buf_full, 1);
        do_alloc(1, 1'b0);
        do_alloc(0, 1'b1);
        cycle();
        drain();

        // R7: flush with completed slots present
        try_alloc(4);
        cycle();
        h = head_m;
        do_write(1, (h + 2) % DEPTH);
        do_write(2, (h + 3) % DEPTH);
        cycle();
        flush = 1'b1;
        cycle();
        chk(buf_empty == 1'b1, "R7 empty after flush", buf_empty, 1);
        chk(rf_we == '0, "R7 no rf write after flush", rf_we, 0);
        rd_tag[TAG_W-1:0] = TAG_W'((h + 2) % DEPTH);
        #1;
        chk(rd_done[0] == 1'b0, "R7 completion flag cleared", rd_done[0], 0);
        exp_q.delete();
        pend.delete();
        alloc_total = retired_total;
        tail_m = head_m;
        try_alloc(1);
        chk(alloc_tag == TAG_W'(h), "R7 next tag at head", alloc_tag, h);
        cycle();
        drain();

        // R4 / R5 / R6: random out-of-order completion
        repeat (600) begin
            int n, pre, k;
            n   = $urandom_range(0, 4);
            pre = pend.size();
            try_alloc(n);
            k = $urandom_range(0, 4);
            for (int p = 0; p < k && pre > 0; p++) begin
                int j;
                j = $urandom_range(0, pre - 1);
                do_write(p, pend[j]);
                pre--;
            end
            cycle();
        end
        drain();

        finish_run();
    end

endmodule